// File: doc/BRIEF.md
# Index Register Flag Execution Unit

This block is the index-register datapath of a small 8-bit processor core. It keeps two index registers, X and Y, and on each strobed cycle carries out one decoded operation on them: load from a memory byte, store to memory, step up or down by one, compare against a memory byte, or move a value between an index register and the accumulator. The accumulator itself lives outside; the block reads it on one input and returns a value plus a one-cycle write enable for it.

Flag results leave the block as values with separate write enables for N, Z, C and V. The external status register latches only the enabled flags, so any flag an operation does not touch keeps its old value. Register updates happen on the rising clock edge. The flag values, the enables, the store data and the accumulator write port all follow the current operation combinationally, within the same cycle.

Top module: `idx_flag_unit`

## Requirements
- R1: A synchronous active-high `rst` clears X and Y to zero. A store operation after reset returns 0x00 on `st_data` for both registers.
- R2: With `valid` high, opcode 1 loads X from `mem_rdata` and opcode 2 loads Y. `flag_n` is bit 7 of the byte and `flag_z` is set when the byte is zero. `n_we` and `z_we` are high and `c_we` is low.
- R3: Opcode 3 drives X on `st_data` and opcode 4 drives Y, each with `st_we` high. No flag enable is raised, `acc_we` stays low, and neither register changes.
- R4: Opcodes 5 and 6 increment X and Y, and opcodes 7 and 8 decrement X and Y. Both are modulo 256: 0xFF steps up to 0x00 and 0x00 steps down to 0xFF. `c_we` stays low.
- R5: During an increment or decrement, `flag_n` is bit 7 of the new value and `flag_z` is set only when the new value is zero. `n_we` and `z_we` are high.
- R6: Opcode 9 compares X and opcode 10 compares Y against `mem_rdata`. `flag_c` is set when the register is unsigned greater than or equal to the byte. `flag_z` is set when they are equal. `flag_n` is bit 7 of (register − byte) mod 256. `n_we`, `z_we` and `c_we` are high, and neither register changes.
- R7: Opcode 11 copies `acc_in` into X and opcode 13 copies it into Y. N and Z follow the copied value, `c_we` and `acc_we` stay low, and the other index register is unchanged.
- R8: Opcode 12 drives X and opcode 14 drives Y on `acc_wdata` with `acc_we` high. N and Z follow that value, and the source register is unchanged. `acc_we` is never high for any other opcode.
- R9: With `valid` low, or with opcode 0 or 15, no register changes. Every write enable (`n_we`, `z_we`, `c_we`, `acc_we`, `st_we`) stays low.
- R10: `v_we` is low for every opcode and in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Operation strobe |
| opcode | input | 4 | Decoded operation code |
| mem_rdata | input | DATA_W | Memory data byte for load and compare |
| acc_in | input | DATA_W | Current accumulator value |
| st_data | output | DATA_W | Store data (selected index register) |
| st_we | output | 1 | Store strobe |
| acc_wdata | output | DATA_W | Value for the accumulator |
| acc_we | output | 1 | Accumulator write enable |
| flag_n | output | 1 | N flag value |
| flag_z | output | 1 | Z flag value |
| flag_c | output | 1 | C flag value |
| n_we | output | 1 | N flag write enable |
| z_we | output | 1 | Z flag write enable |
| c_we | output | 1 | C flag write enable |
| v_we | output | 1 | V flag write enable |

## Verification
The bench builds the block with DATA_W = 8 and the magnitude-comparator compare variant (CMP_STYLE = 1). This setting makes the byte-wrap corners 0x00 and 0xFF reachable in a few directed steps. It also exercises the comparator paths where carry and the sign of the difference disagree, such as 0x40 against 0xC0. The subtract variant computes the same flags, so those same vectors cover its borrow path once the parameter is switched.

// File: rtl/idxu_pkg.sv
package idxu_pkg;

   typedef enum logic [3:0] {
      OP_NOP  = 4'd0,
      OP_LDX  = 4'd1,
      OP_LDY  = 4'd2,
      OP_STX  = 4'd3,
      OP_STY  = 4'd4,
      OP_INX  = 4'd5,
      OP_INY  = 4'd6,
      OP_DEX  = 4'd7,
      OP_DEY  = 4'd8,
      OP_CPX  = 4'd9,
      OP_CPY  = 4'd10,
      OP_TAX  = 4'd11,
      OP_TXA  = 4'd12,
      OP_TAY  = 4'd13,
      OP_TYA  = 4'd14,
      OP_NOP2 = 4'd15
   } idxu_op_e;

   typedef enum logic [1:0] {
      SRC_MEM = 2'd0,
      SRC_ACC = 2'd1,
      SRC_INC = 2'd2,
      SRC_DEC = 2'd3
   } idxu_src_e;

   typedef struct packed {
      logic      sel_y;   // operand / destination is Y
      logic      wr_reg;  // write an index register
      idxu_src_e src;     // value written to the index register
      logic      cmp;     // compare: flags from difference, C enabled
      logic      st;      // store strobe
      logic      to_acc;  // accumulator write
      logic      nz_we;   // N and Z enables
   } idxu_ctrl_t;

   localparam idxu_ctrl_t CTRL_IDLE = '{
      sel_y: 1'b0, wr_reg: 1'b0, src: SRC_MEM, cmp: 1'b0,
      st: 1'b0, to_acc: 1'b0, nz_we: 1'b0};

endpackage

// File: rtl/idxu_decode.sv
module idxu_decode
   import idxu_pkg::*;
#(
   parameter int OPC_W = 4
) (
   input  logic [OPC_W-1:0] opcode,
   output idxu_ctrl_t       ctrl
);

   generate
      if (OPC_W != 4) begin : g_bad_opc
         $error("idxu_decode: OPC_W must be 4");
      end
   endgenerate

   idxu_op_e op;
   assign op = idxu_op_e'(opcode);

   always_comb begin
      ctrl = CTRL_IDLE;
      unique case (op)
         OP_LDX, OP_LDY: begin
            ctrl.sel_y  = (op == OP_LDY);
            ctrl.wr_reg = 1'b1;
            ctrl.src    = SRC_MEM;
            ctrl.nz_we  = 1'b1;
         end
         OP_STX, OP_STY: begin
            ctrl.sel_y = (op == OP_STY);
            ctrl.st    = 1'b1;
         end
         OP_INX, OP_INY: begin
            ctrl.sel_y  = (op == OP_INY);
            ctrl.wr_reg = 1'b1;
            ctrl.src    = SRC_INC;
            ctrl.nz_we  = 1'b1;
         end
         OP_DEX, OP_DEY: begin
            ctrl.sel_y  = (op == OP_DEY);
            ctrl.wr_reg = 1'b1;
            ctrl.src    = SRC_DEC;
            ctrl.nz_we  = 1'b1;
         end
         OP_CPX, OP_CPY: begin
            ctrl.sel_y = (op == OP_CPY);
            ctrl.cmp   = 1'b1;
            ctrl.nz_we = 1'b1;
         end
         OP_TAX, OP_TAY: begin
            ctrl.sel_y  = (op == OP_TAY);
            ctrl.wr_reg = 1'b1;
            ctrl.src    = SRC_ACC;
            ctrl.nz_we  = 1'b1;
         end
         OP_TXA, OP_TYA: begin
            ctrl.sel_y  = (op == OP_TYA);
            ctrl.to_acc = 1'b1;
            ctrl.nz_we  = 1'b1;
         end
         default: ctrl = CTRL_IDLE;
      endcase
   end

endmodule

// File: rtl/idxu_regfile.sv
module idxu_regfile #(
   parameter int DATA_W = 8,
   parameter int NREGS  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_q [NREGS]
);

   generate
      if (NREGS != 2) begin : g_bad_nregs
         $error("idxu_regfile: exactly two index registers are supported");
      end
      if (DATA_W < 2) begin : g_bad_w
         $error("idxu_regfile: DATA_W must be at least 2");
      end
   endgenerate

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      logic hit;
      assign hit = wr_en && (int'(wr_sel) == i);
      always_ff @(posedge clk) begin
         if (rst) begin
            rd_q[i] <= '0;
         end else if (hit) begin
            rd_q[i] <= wr_data;
         end
      end

      // R9
      idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
         !valid |=> $stable(rd_q[i]));
   end

endmodule

// File: rtl/idxu_arith.sv
module idxu_arith #(
   parameter int DATA_W    = 8,
   parameter int CMP_STYLE = 0   // 0: borrow of a wide subtract, 1: magnitude comparator
) (
   input  logic [DATA_W-1:0] opnd,
   input  logic [DATA_W-1:0] mem,
   output logic [DATA_W-1:0] inc_v,
   output logic [DATA_W-1:0] dec_v,
   output logic [DATA_W-1:0] diff,
   output logic              geq,
   output logic              eq
);

   localparam int WIDE_W = DATA_W + 1;
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   assign inc_v = opnd + ONE;
   assign dec_v = opnd - ONE;
   assign eq    = (opnd == mem);

   generate
      if (CMP_STYLE == 0) begin : g_sub
         logic [WIDE_W-1:0] wide;
         assign wide = {1'b0, opnd} - {1'b0, mem};
         assign diff = wide[DATA_W-1:0];
         assign geq  = ~wide[DATA_W];
      end else if (CMP_STYLE == 1) begin : g_mag
         assign diff = opnd - mem;
         assign geq  = (opnd >= mem);
      end else begin : g_bad_style
         $error("idxu_arith: CMP_STYLE must be 0 or 1");
         assign diff = '0;
         assign geq  = 1'b0;
      end
   endgenerate

   // R6
   cmp_eq_geq_chk: assert final (!eq || geq);

endmodule

// File: rtl/idx_flag_unit.sv
module idx_flag_unit
   import idxu_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int OPC_W     = 4,
   parameter int CMP_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] acc_in,
   output logic [DATA_W-1:0] st_data,
   output logic              st_we,
   output logic [DATA_W-1:0] acc_wdata,
   output logic              acc_we,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_c,
   output logic              n_we,
   output logic              z_we,
   output logic              c_we,
   output logic              v_we
);

   localparam int NREGS = 2;
   localparam int MSB   = DATA_W - 1;

   idxu_ctrl_t        ctrl;
   logic [DATA_W-1:0] regs [NREGS];
   logic [DATA_W-1:0] opnd;
   logic [DATA_W-1:0] inc_v, dec_v, diff;
   logic              geq, eq;
   logic [DATA_W-1:0] wr_val;
   logic [DATA_W-1:0] flag_src;

   idxu_decode #(.OPC_W(OPC_W)) u_dec (
      .opcode (opcode),
      .ctrl   (ctrl)
   );

   assign opnd = regs[int'(ctrl.sel_y)];

   idxu_arith #(.DATA_W(DATA_W), .CMP_STYLE(CMP_STYLE)) u_arith (
      .opnd  (opnd),
      .mem   (mem_rdata),
      .inc_v (inc_v),
      .dec_v (dec_v),
      .diff  (diff),
      .geq   (geq),
      .eq    (eq)
   );

   always_comb begin
      unique case (ctrl.src)
         SRC_MEM: wr_val = mem_rdata;
         SRC_ACC: wr_val = acc_in;
         SRC_INC: wr_val = inc_v;
         SRC_DEC: wr_val = dec_v;
         default: wr_val = mem_rdata;
      endcase
   end

   idxu_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
      .clk     (clk),
      .rst     (rst),
      .valid   (valid),
      .wr_en   (valid && ctrl.wr_reg),
      .wr_sel  (ctrl.sel_y),
      .wr_data (wr_val),
      .rd_q    (regs)
   );

   always_comb begin
      if (ctrl.cmp)         flag_src = diff;
      else if (ctrl.to_acc) flag_src = opnd;
      else                  flag_src = wr_val;
   end

   assign flag_n    = flag_src[MSB];
   assign flag_z    = ctrl.cmp ? eq : (flag_src == '0);
   assign flag_c    = geq;
   assign n_we      = valid && ctrl.nz_we;
   assign z_we      = valid && ctrl.nz_we;
   assign c_we      = valid && ctrl.cmp;
   assign v_we      = 1'b0;
   assign st_data   = opnd;
   assign st_we     = valid && ctrl.st;
   assign acc_wdata = opnd;
   assign acc_we    = valid && ctrl.to_acc;

   // R4
   inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (valid && opcode == OPC_W'(OP_INX)) |=> regs[0] == DATA_W'($past(regs[0]) + 1'b1));
   // R4
   dec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (valid && opcode == OPC_W'(OP_DEY)) |=> regs[1] == DATA_W'($past(regs[1]) - 1'b1));
   // R3
   store_hold_chk: assert property (@(posedge clk) disable iff (rst)
      st_we |=> $stable(regs[0]) && $stable(regs[1]));
   // R6
   cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
      c_we |=> $stable(regs[0]) && $stable(regs[1]));
   // R6
   cmp_carry_chk: assert property (@(posedge clk) disable iff (rst)
      c_we |-> (flag_c == !(opnd < mem_rdata)));
   // R8
   acc_we_scope_chk: assert property (@(posedge clk) disable iff (rst)
      acc_we |-> (opcode == OPC_W'(OP_TXA) || opcode == OPC_W'(OP_TYA)));
   // R8
   acc_src_hold_chk: assert property (@(posedge clk) disable iff (rst)
      acc_we |=> $stable(regs[0]) && $stable(regs[1]));
   // R9
   idle_we_chk: assert property (@(posedge clk) disable iff (rst)
      !valid |-> !(n_we || z_we || c_we || acc_we || st_we));

endmodule

// File: tb/idx_flag_unit_tb_top.sv
module idx_flag_unit_tb_top;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         valid = 1'b0;
   logic [3:0]   opcode = 4'd0;
   logic [W-1:0] mem_rdata = '0;
   logic [W-1:0] acc_in = '0;
   logic [W-1:0] st_data, acc_wdata;
   logic         st_we, acc_we, flag_n, flag_z, flag_c, n_we, z_we, c_we, v_we;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   idx_flag_unit #(.DATA_W(W), .OPC_W(4), .CMP_STYLE(1)) dut_i (
      .clk(clk), .rst(rst), .valid(valid), .opcode(opcode),
      .mem_rdata(mem_rdata), .acc_in(acc_in),
      .st_data(st_data), .st_we(st_we), .acc_wdata(acc_wdata), .acc_we(acc_we),
      .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
      .n_we(n_we), .z_we(z_we), .c_we(c_we), .v_we(v_we)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Drive one operation after a falling edge; outputs are sampled 1 ns later.
   task automatic step(input logic v, input logic [3:0] op,
                       input logic [W-1:0] m, input logic [W-1:0] a);
      @(negedge clk);
      valid = v; opcode = op; mem_rdata = m; acc_in = a;
      #1;
      chk("R10 v_we", int'(v_we), 0);
   endtask

   task automatic peek(input logic sel_y, input int exp, input string tag);
      step(1'b1, sel_y ? 4'd4 : 4'd3, '0, '0);
      chk(tag, int'(st_data), exp);
   endtask

   task automatic chk_nz(input string tag, input int n, input int z, input int c_en);
      chk({tag, " flag_n"}, int'(flag_n), n);
      chk({tag, " flag_z"}, int'(flag_z), z);
      chk({tag, " n_we"}, int'(n_we), 1);
      chk({tag, " z_we"}, int'(z_we), 1);
      chk({tag, " c_we"}, int'(c_we), c_en);
   endtask

   task automatic t_reset();
      peek(1'b0, 0, "R1 X after reset");
      chk("R3 st_we", int'(st_we), 1);
      chk("R3 n_we", int'(n_we), 0);
      chk("R3 acc_we", int'(acc_we), 0);
      peek(1'b1, 0, "R1 Y after reset");
   endtask

   task automatic t_load();
      step(1'b1, 4'd1, 8'h80, 8'h00);
      chk_nz("R2 LDX 80", 1, 0, 0);
      step(1'b1, 4'd2, 8'h00, 8'h00);
      chk_nz("R2 LDY 00", 0, 1, 0);
      peek(1'b0, 8'h80, "R2 X loaded");
      peek(1'b1, 8'h00, "R2 Y loaded");
      step(1'b1, 4'd2, 8'h37, 8'h00);
      chk_nz("R2 LDY 37", 0, 0, 0);
      peek(1'b0, 8'h80, "R3 X unchanged by stores");
   endtask

   task automatic t_incdec();
      step(1'b1, 4'd1, 8'hFF, 8'h00);
      step(1'b1, 4'd5, 8'h00, 8'h00);
      chk_nz("R5 INX FF", 0, 1, 0);
      peek(1'b0, 8'h00, "R4 INX wraps to 00");
      step(1'b1, 4'd7, 8'h00, 8'h00);
      chk_nz("R5 DEX 00", 1, 0, 0);
      peek(1'b0, 8'hFF, "R4 DEX wraps to FF");
      step(1'b1, 4'd2, 8'h7F, 8'h00);
      step(1'b1, 4'd6, 8'h00, 8'h00);
      chk_nz("R5 INY 7F", 1, 0, 0);
      step(1'b1, 4'd8, 8'h00, 8'h00);
      chk_nz("R5 DEY 80", 0, 0, 0);
      step(1'b1, 4'd2, 8'h01, 8'h00);
      step(1'b1, 4'd8, 8'h00, 8'h00);
      chk_nz("R5 DEY 01", 0, 1, 0);
      peek(1'b1, 8'h00, "R4 DEY to 00");
      peek(1'b0, 8'hFF, "R4 X untouched by Y ops");
   endtask

   task automatic t_compare();
      step(1'b1, 4'd1, 8'h40, 8'h00);
      step(1'b1, 4'd9, 8'h40, 8'h00);
      chk_nz("R6 CPX equal", 0, 1, 1);
      chk("R6 CPX equal C", int'(flag_c), 1);
      step(1'b1, 4'd9, 8'h41, 8'h00);
      chk_nz("R6 CPX less", 1, 0, 1);
      chk("R6 CPX less C", int'(flag_c), 0);
      step(1'b1, 4'd9, 8'hC0, 8'h00);
      chk_nz("R6 CPX 40-C0", 1, 0, 1);
      chk("R6 CPX 40-C0 C", int'(flag_c), 0);
      step(1'b1, 4'd9, 8'h10, 8'h00);
      chk_nz("R6 CPX greater", 0, 0, 1);
      chk("R6 CPX greater C", int'(flag_c), 1);
      peek(1'b0, 8'h40, "R6 X unchanged by compare");
      step(1'b1, 4'd2, 8'hF0, 8'h00);
      step(1'b1, 4'd10, 8'h10, 8'h00);
      chk_nz("R6 CPY F0-10", 1, 0, 1);
      chk("R6 CPY F0-10 C", int'(flag_c), 1);
      peek(1'b1, 8'hF0, "R6 Y unchanged by compare");
   endtask

   task automatic t_transfer();
      step(1'b1, 4'd2, 8'h5A, 8'h00);
      step(1'b1, 4'd11, 8'h00, 8'h00);
      chk_nz("R7 TAX 00", 0, 1, 0);
      chk("R7 TAX acc_we", int'(acc_we), 0);
      step(1'b1, 4'd12, 8'h00, 8'hEE);
      chk("R8 TXA acc_wdata", int'(acc_wdata), 8'h00);
      chk("R8 TXA acc_we", int'(acc_we), 1);
      chk_nz("R8 TXA", 0, 1, 0);
      peek(1'b1, 8'h5A, "R7 Y untouched by TAX");
      step(1'b1, 4'd13, 8'h00, 8'h9C);
      chk_nz("R7 TAY 9C", 1, 0, 0);
      chk("R7 TAY acc_we", int'(acc_we), 0);
      step(1'b1, 4'd14, 8'h00, 8'h11);
      chk("R8 TYA acc_wdata", int'(acc_wdata), 8'h9C);
      chk("R8 TYA acc_we", int'(acc_we), 1);
      chk_nz("R8 TYA", 1, 0, 0);
      peek(1'b1, 8'h9C, "R8 Y preserved by TYA");
      peek(1'b0, 8'h00, "R8 X preserved by TXA");
      chk("R8 no acc_we on store", int'(acc_we), 0);
   endtask

   task automatic t_idle();
      step(1'b1, 4'd1, 8'h22, 8'h00);
      step(1'b0, 4'd1, 8'h55, 8'h00);
      chk("R9 idle n_we", int'(n_we), 0);
      chk("R9 idle z_we", int'(z_we), 0);
      chk("R9 idle st_we", int'(st_we), 0);
      step(1'b0, 4'd12, 8'h00, 8'h00);
      chk("R9 idle acc_we", int'(acc_we), 0);
      step(1'b1, 4'd0, 8'h66, 8'h00);
      chk("R9 op0 enables", int'({n_we, z_we, c_we, acc_we, st_we}), 0);
      step(1'b1, 4'd15, 8'h77, 8'h00);
      chk("R9 op15 enables", int'({n_we, z_we, c_we, acc_we, st_we}), 0);
      peek(1'b0, 8'h22, "R9 X unchanged while idle");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_load();
      t_incdec();
      t_compare();
      t_transfer();
      t_idle();
      @(negedge clk);
      valid = 1'b0;
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule